// File: doc/BRIEF.md
# I2C Bit-Rate Tick Generator

This block derives the timing reference for an I2C master from the system clock. It keeps a 7-bit rate register that holds two divider fields: a 4-bit linear factor M and a 3-bit exponent N. The system clock passes through two counters in series. The first is a power-of-two prescaler and the second divides by M+1. Each time the second counter completes, the block emits one sub-tick. Ten sub-ticks make one SCL period, so the SCL rate is the system clock divided by ten times the tick spacing.

A 4-bit sub-phase index also counts the sub-ticks, modulo ten. The bit engine uses it to place the phases of each SCL period. A synchronous soft reset returns the rate register to its default. A soft reset or a register write also restarts the counters, so the first period after a change is never cut short.

A build-time parameter chooses the exponent form. The default divides the first stage by 2^(N+1). The alternate form divides it by 2^N.

Top module: `i2c_rate_gen`

## Requirements
- R1: With the default exponent form, `tick` pulses every (M+1)·2^(N+1) clock cycles, where M = rate[6:3] and N = rate[2:0].
- R2: With EXP_PLUS_ONE = 0, `tick` pulses every (M+1)·2^N clock cycles, using the same field positions.
- R3: After the asynchronous reset, the rate register holds 0x44 (M=8, N=4). `tick` and `subPhase` are 0 while reset is held, and the first tick arrives one full period after reset is released.
- R4: A soft reset restores the rate 0x44 and restarts the counters. When `softRst` and `wrEn` are both high in the same cycle, `softRst` wins and the write data is discarded.
- R5: A write loads `wrData` and restarts both counters from zero. The next tick arrives exactly one new period after the write edge, even if the write lands part way through a period.
- R6: When the period is longer than one cycle, `tick` is high for exactly one clock cycle.
- R7: `subPhase` changes on the same edge as each tick. It equals the number of ticks since the last restart, modulo 10. It wraps from 9 to 0, and a restart clears it to 0.
- R8: In the alternate form with M=0 and N=0, `tick` is high on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| softRst | input | 1 | Synchronous soft reset: restores the default rate and restarts the counters |
| wrEn | input | 1 | Write strobe for the rate register |
| wrData | input | 7 | New rate value: M in bits 6:3, N in bits 2:0 |
| tick | output | 1 | Sub-tick pulse, ten per SCL period |
| subPhase | output | 4 | Sub-tick count modulo 10 |

## Verification
The bench builds two instances that share their inputs: one with the default exponent form and one with EXP_PLUS_ONE = 0. This lets every rate value be measured against both divider formulas in the same run. The alternate instance makes the degenerate one-cycle period (M=0, N=0) reachable. The default instance makes the longest period, 4096 cycles at M=15 and N=7, reachable. Between them they cover the counter limits at both ends.

// File: rtl/i2c_rate_pkg.sv
package i2c_rate_pkg;
  localparam int SUB_TICKS = 10;
  localparam int PH_W = $clog2(SUB_TICKS);

  typedef struct packed {
    logic restart;
  } rate_strobe_t;
endpackage

// File: rtl/i2c_rate_ctrl.sv
module i2c_rate_ctrl
  import i2c_rate_pkg::*;
#(
  parameter int M_W = 4,
  parameter int N_W = 3,
  parameter int RESET_BAUD = 68
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               softRst,
  input  logic               wrEn,
  input  logic [M_W+N_W-1:0] wrData,
  output rate_strobe_t       strobe,
  output logic [M_W-1:0]     mVal,
  output logic [N_W-1:0]     nVal
);
  localparam int BAUD_W = M_W + N_W;
  localparam logic [BAUD_W-1:0] BAUD_RST = BAUD_W'(RESET_BAUD);

  logic [BAUD_W-1:0] baudReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        baudReg <= BAUD_RST;
    else if (softRst) baudReg <= BAUD_RST;
    else if (wrEn)    baudReg <= wrData;
  end

  always_comb begin
    strobe.restart = softRst | wrEn;
  end

  assign mVal = baudReg[BAUD_W-1:N_W];
  assign nVal = baudReg[N_W-1:0];
endmodule

// File: rtl/i2c_rate_dp.sv
module i2c_rate_dp
  import i2c_rate_pkg::*;
#(
  parameter int M_W = 4,
  parameter int N_W = 3,
  parameter bit EXP_PLUS_ONE = 1'b1
) (
  input  logic            clk,
  input  logic            rstN,
  input  rate_strobe_t    strobe,
  input  logic [M_W-1:0]  mVal,
  input  logic [N_W-1:0]  nVal,
  output logic            tick,
  output logic [PH_W-1:0] subPhase
);
  localparam int EXTRA   = EXP_PLUS_ONE ? 1 : 0;
  localparam int MAX_EXP = (1 << N_W) - 1 + EXTRA;
  localparam int PRE_W   = (MAX_EXP < 1) ? 1 : MAX_EXP;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(SUB_TICKS - 1);

  logic [N_W:0]      expo;
  logic [PRE_W-1:0]  preLimit;
  logic [PRE_W-1:0]  preCnt;
  logic [M_W-1:0]    mainCnt;
  logic              preDone;
  logic              mainDone;

  generate
    if (EXP_PLUS_ONE) begin : g_exp_plus
      assign expo = {1'b0, nVal} + (N_W+1)'(1);
    end else begin : g_exp_plain
      assign expo = {1'b0, nVal};
    end
  endgenerate

  // Terminal count of the first stage: 2^expo - 1, as a run of low ones
  always_comb begin
    for (int i = 0; i < PRE_W; i++) begin
      preLimit[i] = (i < int'(expo));
    end
  end

  assign preDone  = (preCnt == preLimit);
  assign mainDone = preDone && (mainCnt == mVal);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt   <= '0;
      mainCnt  <= '0;
      tick     <= 1'b0;
      subPhase <= '0;
    end else if (strobe.restart) begin
      preCnt   <= '0;
      mainCnt  <= '0;
      tick     <= 1'b0;
      subPhase <= '0;
    end else begin
      preCnt <= preDone ? '0 : preCnt + PRE_W'(1);
      if (preDone) begin
        mainCnt <= mainDone ? '0 : mainCnt + M_W'(1);
      end
      tick <= mainDone;
      if (mainDone) begin
        subPhase <= (subPhase == PH_LAST) ? '0 : subPhase + PH_W'(1);
      end
    end
  end
endmodule

// File: rtl/i2c_rate_gen.sv
module i2c_rate_gen
  import i2c_rate_pkg::*;
#(
  parameter int M_W = 4,
  parameter int N_W = 3,
  parameter int RESET_BAUD = 68,
  parameter bit EXP_PLUS_ONE = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               softRst,
  input  logic               wrEn,
  input  logic [M_W+N_W-1:0] wrData,
  output logic               tick,
  output logic [PH_W-1:0]    subPhase
);
  rate_strobe_t   strobe;
  logic [M_W-1:0] mVal;
  logic [N_W-1:0] nVal;

  i2c_rate_ctrl #(.M_W(M_W), .N_W(N_W), .RESET_BAUD(RESET_BAUD)) u_ctrl (
    .clk(clk), .rstN(rstN), .softRst(softRst), .wrEn(wrEn), .wrData(wrData),
    .strobe(strobe), .mVal(mVal), .nVal(nVal)
  );

  i2c_rate_dp #(.M_W(M_W), .N_W(N_W), .EXP_PLUS_ONE(EXP_PLUS_ONE)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .mVal(mVal), .nVal(nVal),
    .tick(tick), .subPhase(subPhase)
  );
endmodule

// File: rtl/i2c_rate_gen_chk.sv
module i2c_rate_gen_chk
  import i2c_rate_pkg::*;
#(
  parameter int M_W = 4,
  parameter int N_W = 3,
  parameter int RESET_BAUD = 68,
  parameter bit EXP_PLUS_ONE = 1'b1
) (
  input logic               clk,
  input logic               rstN,
  input logic               softRst,
  input logic               wrEn,
  input logic [M_W+N_W-1:0] wrData,
  input logic               tick,
  input logic [PH_W-1:0]    subPhase
);
  localparam int BAUD_W = M_W + N_W;
  localparam int EXTRA  = EXP_PLUS_ONE ? 1 : 0;

  logic [BAUD_W-1:0] shadow;
  int gapCnt;
  int expPeriod;

  // Independent model of the rate value and of the elapsed cycles since the last event
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadow <= BAUD_W'(RESET_BAUD);
      gapCnt <= 0;
    end else begin
      if (softRst)   shadow <= BAUD_W'(RESET_BAUD);
      else if (wrEn) shadow <= wrData;
      if (softRst || wrEn) gapCnt <= 0;
      else if (tick)       gapCnt <= 1;
      else                 gapCnt <= gapCnt + 1;
    end
  end

  assign expPeriod = (int'(shadow[BAUD_W-1:N_W]) + 1) << (int'(shadow[N_W-1:0]) + EXTRA);

  // R1 / R2: tick comes exactly one period after the last tick or restart
  p_tick_spacing_r1: assert property (@(posedge clk) disable iff (!rstN)
    tick == (gapCnt == expPeriod));

  // R4: a soft reset clears the tick and the phase
  p_soft_reset_r4: assert property (@(posedge clk) disable iff (!rstN)
    softRst |=> (!tick && subPhase == '0));

  // R5: a write restarts everything
  p_write_restart_r5: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> (!tick && subPhase == '0));

  // R7: the phase stays below ten
  p_phase_range_r7: assert property (@(posedge clk) disable iff (!rstN)
    subPhase < PH_W'(SUB_TICKS));

  // R7: the phase advances by one, wrapping, whenever a tick shows
  p_phase_step_r7: assert property (@(posedge clk) disable iff (!rstN)
    tick |-> subPhase == (($past(subPhase) == PH_W'(SUB_TICKS - 1)) ? '0 : $past(subPhase) + PH_W'(1)));

  // R7: the phase holds between ticks unless a restart clears it
  p_phase_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!tick && !$past(softRst) && !$past(wrEn)) |-> $stable(subPhase));
endmodule

bind i2c_rate_gen i2c_rate_gen_chk #(
  .M_W(M_W), .N_W(N_W), .RESET_BAUD(RESET_BAUD), .EXP_PLUS_ONE(EXP_PLUS_ONE)
) u_chk (
  .clk(clk), .rstN(rstN), .softRst(softRst), .wrEn(wrEn), .wrData(wrData),
  .tick(tick), .subPhase(subPhase)
);

// File: tb/i2c_rate_gen_bench.sv
module i2c_rate_gen_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       softRst = 1'b0;
  logic       wrEn = 1'b0;
  logic [6:0] wrData = '0;
  logic       tickMain, tickAlt;
  logic [3:0] phaseMain, phaseAlt;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  i2c_rate_gen u_i2c_rate_gen (
    .clk(clk), .rstN(rstN), .softRst(softRst), .wrEn(wrEn), .wrData(wrData),
    .tick(tickMain), .subPhase(phaseMain)
  );

  i2c_rate_gen #(.EXP_PLUS_ONE(1'b0)) u_i2c_rate_gen_alt (
    .clk(clk), .rstN(rstN), .softRst(softRst), .wrEn(wrEn), .wrData(wrData),
    .tick(tickAlt), .subPhase(phaseAlt)
  );

  localparam int NV = 8;
  localparam int VEC_M   [NV] = '{0, 1, 3, 8, 2, 15, 4, 0};
  localparam int VEC_N   [NV] = '{0, 0, 1, 4, 2, 7, 3, 5};
  localparam int EXP_DEF [NV] = '{2, 4, 16, 288, 24, 4096, 80, 64};
  localparam int EXP_ALT [NV] = '{1, 2, 8, 144, 12, 2048, 40, 32};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic writeRate(input int m, input int n);
    @(negedge clk);
    wrEn = 1'b1;
    wrData = 7'((m << 3) | n);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // Counts falling edges until the selected tick is seen high
  task automatic measure(input bit alt, output int gap);
    gap = 0;
    do begin
      @(negedge clk);
      gap++;
    end while (!(alt ? tickAlt : tickMain) && gap < 10000);
  endtask

  initial begin
    int g;
    // R3: reset state
    #23;
    check(tickMain == 1'b0 && tickAlt == 1'b0, "R3 tick in reset", int'(tickMain), 0);
    check(phaseMain == 4'd0, "R3 phase in reset", int'(phaseMain), 0);
    @(negedge clk);
    rstN = 1'b1;
    measure(1'b0, g);
    check(g == 288, "R3 first tick after reset (default form)", g, 288);
    measure(1'b1, g);
    check(g == 144, "R3 reset rate (alternate form)", g, 144);

    // R1 / R2: table of rate values
    for (int v = 0; v < NV; v++) begin
      writeRate(VEC_M[v], VEC_N[v]);
      for (int k = 0; k < 3; k++) begin
        measure(1'b0, g);
        check(g == EXP_DEF[v], "R1 tick spacing", g, EXP_DEF[v]);
      end
      writeRate(VEC_M[v], VEC_N[v]);
      for (int k = 0; k < 3; k++) begin
        measure(1'b1, g);
        check(g == EXP_ALT[v], "R2 tick spacing", g, EXP_ALT[v]);
      end
    end

    // R7 / R6 / R8: phase count and pulse width with M=0, N=0
    writeRate(0, 0);
    for (int k = 1; k <= 12; k++) begin
      measure(1'b0, g);
      check(phaseMain == 4'(k % 10), "R7 phase after tick", int'(phaseMain), k % 10);
      check(tickAlt == 1'b1, "R8 alternate tick every cycle", int'(tickAlt), 1);
      @(negedge clk);
      check(tickMain == 1'b0, "R6 one-cycle tick", int'(tickMain), 0);
      check(tickAlt == 1'b1, "R8 alternate tick every cycle", int'(tickAlt), 1);
    end
    writeRate(0, 0);
    check(phaseMain == 4'd0 && tickMain == 1'b0, "R7 restart clears phase", int'(phaseMain), 0);

    // R5: rewrite part way through a period
    writeRate(3, 1);
    repeat (7) @(negedge clk);
    writeRate(3, 1);
    measure(1'b0, g);
    check(g == 16, "R5 full period after mid-period write", g, 16);
    check(phaseMain == 4'd1, "R5 phase restarted", int'(phaseMain), 1);

    // R4: soft reset restores the default rate
    writeRate(1, 0);
    @(negedge clk);
    softRst = 1'b1;
    @(negedge clk);
    softRst = 1'b0;
    check(phaseMain == 4'd0 && tickMain == 1'b0, "R4 soft reset clears phase", int'(phaseMain), 0);
    measure(1'b0, g);
    check(g == 288, "R4 rate after soft reset", g, 288);

    // R4: soft reset beats a simultaneous write
    @(negedge clk);
    softRst = 1'b1;
    wrEn = 1'b1;
    wrData = 7'h00;
    @(negedge clk);
    softRst = 1'b0;
    wrEn = 1'b0;
    measure(1'b1, g);
    check(g == 144, "R4 soft reset has priority over write", g, 144);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule